// File: doc/BRIEF.md
# Keyed Reset and Interrupt Control Register

This block is a single 32-bit system control register. Software writes to it to request resets and to set the interrupt priority grouping. A write changes nothing unless its upper half carries the write key. This guard stops stray stores from resetting the system.

An accepted write can do four things:
- raise a system reset request toward an external reset controller;
- emit a one-cycle local core reset pulse;
- emit a one-cycle pulse that clears active exception state;
- load the priority grouping and secure-only fields.

Reads return a fixed pattern in the upper half, which differs from the write key. The lower half reports the endianness tie-off and the stored fields.

The system reset request is sticky. It stays high until the block's synchronous reset, which is the local reset, clears it. The reset controller and the exception logic that consume these outputs sit outside the block.

Top module: `keyed_rst_ctl`

## Requirements
- R1: A write (`wr_en`=1) whose bits [31:16] differ from 0x05FA changes no output and no stored field.
- R2: A write whose bits [31:16] equal 0x05FA loads bits [10:8] into `prio_grp` and bit 3 into `sec_only`. Both are visible the cycle after the write edge.
- R3: A read (`rd_en`=1) updates `rdata` on the next edge. `rdata` then holds the following, taken from the state before that edge, until the next read:
  - bits [31:16] = 0xFA05;
  - bit 15 = endianness (0 = little);
  - bits [10:8] = `prio_grp`;
  - bit 3 = `sec_only`;
  - bit 2 = `sys_rst_req`;
  - all other bits 0.
- R4: With the default tie-off, `rdata` bit 15 reads 0 (little endian).
- R5: A keyed write with bit 2 set drives `sys_rst_req` high from the next cycle. It stays high through any later write and is cleared only by `rst`.
- R6: A keyed write with bit 0 set and bit 2 clear makes `core_rst_pulse` high for exactly the next cycle. A keyed write with bit 1 set makes `clr_active_pulse` high for exactly the next cycle.
- R7: A keyed write that sets both bit 0 and bit 2 raises only `sys_rst_req`. No `core_rst_pulse` is produced.
- R8: While `rst` is high at an edge, every output returns to 0 after that edge. This includes `prio_grp`=000, `sec_only`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high local reset |
| wr_en | input | 1 | Write strobe for `wdata` |
| wdata | input | 32 | Write data, key in [31:16] |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read image |
| sys_rst_req | output | 1 | Sticky system reset request |
| core_rst_pulse | output | 1 | One-cycle local core reset request |
| clr_active_pulse | output | 1 | One-cycle clear-active-exception request |
| prio_grp | output | 3 | Priority grouping field |
| sec_only | output | 1 | System reset restricted to secure state |

## Verification
The assertions assume that `wr_en`, `rd_en` and `wdata` are settled before each rising edge. They also assume that `rst` is the only thing that clears the system request.

The checker recomputes the key match from `wdata` on its own, so a rejected write, whatever its low bits, must leave every field stable.

The stimulus changes inputs only on falling edges. It mixes keyed and unkeyed writes, including the read pattern used as a write key, back-to-back writes, combined bit 0 and bit 2 writes, and a pseudo-random sweep. Reset is applied mid-run while a request is pending.

// File: rtl/krc_pkg.sv
package krc_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned KEY_W       = 16;
  localparam int unsigned KEY_LSB     = REG_W - KEY_W;
  localparam int unsigned ENDIAN_BIT  = 15;
  localparam int unsigned PRIO_W      = 3;
  localparam int unsigned PRIO_LSB    = 8;
  localparam int unsigned SECONLY_BIT = 3;
  localparam int unsigned SYSREQ_BIT  = 2;
  localparam int unsigned CLRACT_BIT  = 1;
  localparam int unsigned CORERST_BIT = 0;

  typedef struct packed {
    logic              sys_req;
    logic              sec_only;
    logic [PRIO_W-1:0] prio;
  } krc_state_t;
endpackage

// File: rtl/krc_key_gate.sv
module krc_key_gate #(
  parameter int unsigned KEY_W  = 16,
  parameter logic [KEY_W-1:0] WR_KEY = '0
) (
  input  logic             wr_en,
  input  logic [KEY_W-1:0] key,
  output logic             accept
);
  always_comb accept = wr_en && (key == WR_KEY);
endmodule

// File: rtl/krc_ctrl_regs.sv
module krc_ctrl_regs
  import krc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              req_core,
  input  logic              req_clr,
  input  logic              req_sys,
  input  logic              new_sec,
  input  logic [PRIO_W-1:0] new_prio,
  output krc_state_t        state,
  output logic              core_pulse,
  output logic              clr_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= '0;
      core_pulse <= 1'b0;
      clr_pulse  <= 1'b0;
    end else begin
      // System request wins over a local core reset in the same write.
      core_pulse <= accept && req_core && !req_sys;
      clr_pulse  <= accept && req_clr;
      if (accept) begin
        state.prio     <= new_prio;
        state.sec_only <= new_sec;
        if (req_sys) state.sys_req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/krc_read_port.sv
module krc_read_port
  import krc_pkg::*;
#(
  parameter logic [KEY_W-1:0] RD_KEY     = '0,
  parameter bit               BIG_ENDIAN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  krc_state_t       state,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] image;

  always_comb begin
    image = '0;
    image[REG_W-1:KEY_LSB]           = RD_KEY;
    image[ENDIAN_BIT]                = BIG_ENDIAN;
    image[PRIO_LSB +: PRIO_W]        = state.prio;
    image[SECONLY_BIT]               = state.sec_only;
    image[SYSREQ_BIT]                = state.sys_req;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= image;
  end
endmodule

// File: rtl/keyed_rst_ctl.sv
module keyed_rst_ctl
  import krc_pkg::*;
#(
  parameter logic [15:0] WR_KEY     = 16'h05FA,
  parameter logic [15:0] RD_KEY     = 16'hFA05,
  parameter bit          BIG_ENDIAN = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        rd_en,
  output logic [31:0] rdata,
  output logic        sys_rst_req,
  output logic        core_rst_pulse,
  output logic        clr_active_pulse,
  output logic [2:0]  prio_grp,
  output logic        sec_only
);
  logic       accept;
  krc_state_t state;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata[ENDIAN_BIT:PRIO_LSB+PRIO_W], wdata[PRIO_LSB-1:SECONLY_BIT+1]};

  krc_key_gate #(.KEY_W(KEY_W), .WR_KEY(WR_KEY)) gate_i (
    .wr_en (wr_en),
    .key   (wdata[REG_W-1:KEY_LSB]),
    .accept(accept)
  );

  krc_ctrl_regs regs_i (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_core  (wdata[CORERST_BIT]),
    .req_clr   (wdata[CLRACT_BIT]),
    .req_sys   (wdata[SYSREQ_BIT]),
    .new_sec   (wdata[SECONLY_BIT]),
    .new_prio  (wdata[PRIO_LSB +: PRIO_W]),
    .state     (state),
    .core_pulse(core_rst_pulse),
    .clr_pulse (clr_active_pulse)
  );

  krc_read_port #(.RD_KEY(RD_KEY), .BIG_ENDIAN(BIG_ENDIAN)) rd_i (
    .clk  (clk),
    .rst  (rst),
    .rd_en(rd_en),
    .state(state),
    .rdata(rdata)
  );

  assign sys_rst_req = state.sys_req;
  assign prio_grp    = state.prio;
  assign sec_only    = state.sec_only;
endmodule

// File: rtl/keyed_rst_ctl_chk.sv
module keyed_rst_ctl_chk #(
  parameter logic [15:0] WR_KEY = 16'h05FA,
  parameter logic [15:0] RD_KEY = 16'hFA05
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wdata,
  input logic        rd_en,
  input logic [31:0] rdata,
  input logic        sys_rst_req,
  input logic        core_rst_pulse,
  input logic        clr_active_pulse,
  input logic [2:0]  prio_grp,
  input logic        sec_only
);
  logic keyed;
  assign keyed = wr_en && (wdata[31:16] == WR_KEY);

  AST_REJECT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !keyed) |=> ($stable(prio_grp) && $stable(sec_only) && !core_rst_pulse && !clr_active_pulse)); // R1
  AST_SYSREQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> sys_rst_req); // R5
  AST_SYSREQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_req) |-> $past(keyed && wdata[2])); // R5
  AST_CORE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    core_rst_pulse |-> $past(keyed && wdata[0])); // R6
  AST_CORE_YIELDS: assert property (@(posedge clk) disable iff (rst)
    core_rst_pulse |-> !$past(wdata[2])); // R7
  AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    clr_active_pulse |-> $past(keyed && wdata[1])); // R6
  AST_READ_KEY: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !rst) |-> (rdata[31:16] == RD_KEY)); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sys_rst_req && prio_grp == 3'd0 && !sec_only && rdata == 32'd0)); // R8
endmodule

bind keyed_rst_ctl keyed_rst_ctl_chk #(.WR_KEY(WR_KEY), .RD_KEY(RD_KEY)) chk_i (.*);

// File: tb/keyed_rst_ctl_tb_top.sv
module keyed_rst_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        sys_rst_req, core_rst_pulse, clr_active_pulse, sec_only;
  logic [2:0]  prio_grp;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic        m_sys, m_core, m_clr, m_sec;
  logic [2:0]  m_prio;
  logic [31:0] m_rdata;

  always #5 clk = ~clk;

  keyed_rst_ctl dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic acc;
    acc = wr_en && (wdata[31:16] == 16'h05FA);
    if (rst) begin
      m_sys = 0; m_core = 0; m_clr = 0; m_sec = 0; m_prio = 0; m_rdata = 0;
    end else begin
      if (rd_en)
        m_rdata = {16'hFA05, 1'b0, 4'b0, m_prio, 4'b0, m_sec, m_sys, 2'b00};
      m_core = acc && wdata[0] && !wdata[2];
      m_clr  = acc && wdata[1];
      if (acc) begin
        m_prio = wdata[10:8];
        m_sec  = wdata[3];
        if (wdata[2]) m_sys = 1;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    chk("R2 prio_grp", {29'd0, prio_grp}, {29'd0, m_prio});
    chk("R2 sec_only", {31'd0, sec_only}, {31'd0, m_sec});
    chk("R5 sys_rst_req", {31'd0, sys_rst_req}, {31'd0, m_sys});
    chk("R6 R7 core_rst_pulse", {31'd0, core_rst_pulse}, {31'd0, m_core});
    chk("R6 clr_active_pulse", {31'd0, clr_active_pulse}, {31'd0, m_clr});
    chk("R3 rdata", rdata, m_rdata);
  endtask

  task automatic wr(input logic [15:0] key, input logic [15:0] lo);
    wr_en = 1; wdata = {key, lo}; tick(); wr_en = 0; wdata = '0;
  endtask

  task automatic rd();
    rd_en = 1; tick(); rd_en = 0;
  endtask

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1234_5678;
    rst = 1; tick(); tick();
    rst = 0; tick();
    chk("R8 reset outputs", {rdata[31:0]}, 32'd0);
    rd();
    chk("R4 little endian bit", {31'd0, rdata[15]}, 32'd0);
    chk("R3 read key", {16'd0, rdata[31:16]}, 32'h0000_FA05);
    // R1: read pattern used as write key, and other bad keys, all bits set
    wr(16'hFA05, 16'hFFFF); wr(16'h0000, 16'h070F); wr(16'h05FB, 16'h0707);
    rd();
    chk("R1 rejected writes", rdata, 32'hFA05_0000);
    // R2: keyed field load
    wr(16'h05FA, 16'h0508); rd(); tick();
    chk("R2 fields read", rdata, 32'hFA05_0508);
    // R6: pulses
    wr(16'h05FA, 16'h0501); tick();
    wr(16'h05FA, 16'h0502); tick();
    wr(16'h05FA, 16'h0503); wr(16'h05FA, 16'h0501);
    // R7: bit0 with bit2
    wr(16'h05FA, 16'h0005); tick();
    chk("R7 sys only", {30'd0, sys_rst_req, core_rst_pulse}, 32'd2);
    // R5: stays through later writes with bit2 clear
    wr(16'h05FA, 16'h0300); wr(16'h1111, 16'h0000); rd(); tick();
    chk("R5 sys held in read", {31'd0, rdata[2]}, 32'd1);
    // R8: reset mid-run
    rst = 1; rd_en = 1; tick(); rst = 0; rd_en = 0; tick();
    chk("R8 sys cleared", {31'd0, sys_rst_req}, 32'd0);
    // sweep
    for (int i = 0; i < 300; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      wr_en = lfsr[0];
      rd_en = lfsr[1];
      wdata = {lfsr[2] ? 16'h05FA : lfsr[31:16], lfsr[15:0] & 16'h87FB};
      rst = (lfsr[7:3] == 5'd0);
      tick();
    end
    wr_en = 0; rd_en = 0; rst = 0;
    tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule